// File: doc/BRIEF.md
# Byte-Serial Grouped Register Adder

This block owns a 64-byte register file, addressed in octal from R0 to R77, and adds one multi-byte operand held in it to another, one byte per clock. A command carries a destination pointer, a source pointer and a mode bit that selects plain binary or packed-BCD arithmetic. No length field is given. The operand runs from the destination byte up to the top of its eight-byte group, so a destination of R60 yields an 8-byte (64-bit) add and a destination of R76 yields a 2-byte add. The source pointer steps forward in lock-step.

Bytes are least significant at the lowest address, so the running carry moves upward through the group. Each sum byte replaces the destination byte it came from. Four setup cycles precede the byte cycles. `done` pulses once when the operation ends, and the carry out of the top byte stays on `carry_out` until the next accepted command. A separate byte-wide host port loads and reads the register file while the sequencer is idle.

Top module: `regfile_serial_adder`

## Requirements
- R1: After reset, `busy`, `done` and `carry_out` are all 0.
- R2: The byte count B equals 8 minus the low three bits of `dst_ptr`. Only destination bytes `dst_ptr` through the top of its group change, and every other register keeps its value.
- R3: In binary mode (`bcd_mode`=0) the destination receives the B-byte sum of destination and source. The lower address is the less significant byte, and the carry starts at 0 and ripples upward.
- R4: In BCD mode (`bcd_mode`=1) each byte is two packed digits, with bits 3:0 as the lower digit. Each digit is added with the incoming carry. A raw digit sum above 9 is corrected by adding 6 (modulo 16) and passes a carry of 1 to the next digit.
- R5: `busy` is high for exactly 4+B cycles, starting with the cycle after the accepting clock edge. `done` is high for exactly one cycle, the one in which `busy` has just fallen.
- R6: The source address steps by one per byte modulo 64, with no check of its own group boundary. A source of R73 under a destination of R70 reads R73..R77 and then R0..R2.
- R7: `carry_out` is cleared on an accepted start. It takes the carry out of the most significant byte in the same cycle that `done` rises, and then holds until the next accepted start.
- R8: A `start` that arrives while `busy` is high is ignored. It neither alters the running operation nor begins a new one.
- R9: Host port: when `busy` is low, `host_we` writes `host_wdata` to `host_addr` at the clock edge. When `busy` is high, host writes are dropped. `host_rdata` shows the byte at `host_addr` one clock after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command request, taken only while idle |
| dst_ptr | input | 6 | Destination byte address; its low 3 bits set the length |
| src_ptr | input | 6 | Source byte address |
| bcd_mode | input | 1 | 1 selects packed-BCD arithmetic, 0 selects binary |
| host_we | input | 1 | Host byte write enable |
| host_addr | input | 6 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| carry_out | output | 1 | Final carry of the last operation |

## Verification
The hardest situation to create from the ports is a colliding request that lands in the middle of a running add. This means a second `start` with different pointers and mode, together with a host write aimed at a destination byte that has not yet been summed. The driver reaches it by raising both requests for one cycle, a fixed number of cycles after the accepting edge, so the collision falls inside the setup phase of a full-length add. A spurious second `done` would show it was not ignored, and so would a wrong busy length or a changed byte in the final register dump. Source wrap past R77 is reached by placing the source in the last group under a full-length destination.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LATCH = 3'd1,
    ST_LEN   = 3'd2,
    ST_CLR   = 3'd3,
    ST_ARM   = 3'd4,
    ST_BYTE  = 3'd5
  } seq_state_e;
endpackage

// File: rtl/rsa_regfile.sv
module rsa_regfile #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b,
  input  logic [ADDR_W-1:0] haddr,
  output logic [DATA_W-1:0] hdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // single write port, no reset on the storage
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // operand reads are asynchronous (distributed storage)
  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  // host read is registered, read-before-write
  always_ff @(posedge clk) begin
    hdata <= mem[haddr];
  end
endmodule

// File: rtl/rsa_byte_adder.sv
module rsa_byte_adder #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              bcd,
  output logic [DATA_W-1:0] sum,
  output logic              cout
);
  localparam int DIGITS = DATA_W / 4;

  logic [DATA_W:0]   bin_full;
  logic [DATA_W-1:0] dec_sum;
  logic              dec_cout;

  assign bin_full = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};

  // digit chain: raw digit sum above nine gets +6 and a decimal carry
  always_comb begin
    logic       c;
    logic [4:0] raw;
    c       = cin;
    dec_sum = '0;
    for (int g = 0; g < DIGITS; g++) begin
      raw = {1'b0, a[4*g +: 4]} + {1'b0, b[4*g +: 4]} + {4'b0, c};
      if (raw > 5'd9) begin
        dec_sum[4*g +: 4] = raw[3:0] + 4'd6;
        c = 1'b1;
      end else begin
        dec_sum[4*g +: 4] = raw[3:0];
        c = 1'b0;
      end
    end
    dec_cout = c;
  end

  assign sum  = bcd ? dec_sum  : bin_full[DATA_W-1:0];
  assign cout = bcd ? dec_cout : bin_full[DATA_W];
endmodule

// File: rtl/rsa_sequencer.sv
module rsa_sequencer
  import rsa_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int GRP_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic              bcd_i,
  input  logic              cout_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              carry_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] dptr_o,
  output logic [ADDR_W-1:0] sptr_o,
  output logic              bcd_o,
  output logic              cin_o
);
  localparam int              LEN_W     = GRP_W + 1;
  localparam logic [LEN_W-1:0] GRP_BYTES = LEN_W'(1 << GRP_W);

  seq_state_e          state_q;
  logic [ADDR_W-1:0]   dptr_q, sptr_q;
  logic [ADDR_W-GRP_W-1:0] grp_q;
  logic                mode_q;
  logic [LEN_W-1:0]    rem_q;
  logic                carry_q;
  logic                busy_q, done_q, cout_q;
  logic                accept;

  assign accept = start_i && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      dptr_q  <= '0;
      sptr_q  <= '0;
      grp_q   <= '0;
      mode_q  <= 1'b0;
      rem_q   <= '0;
      carry_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cout_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            dptr_q  <= dst_i;
            sptr_q  <= src_i;
            grp_q   <= dst_i[ADDR_W-1:GRP_W];
            mode_q  <= bcd_i;
            cout_q  <= 1'b0;
            busy_q  <= 1'b1;
            state_q <= ST_LATCH;
          end
        end
        ST_LATCH: state_q <= ST_LEN;
        ST_LEN: begin
          rem_q   <= GRP_BYTES - {1'b0, dptr_q[GRP_W-1:0]};
          state_q <= ST_CLR;
        end
        ST_CLR: begin
          carry_q <= 1'b0;
          state_q <= ST_ARM;
        end
        ST_ARM: state_q <= ST_BYTE;
        ST_BYTE: begin
          carry_q <= cout_i;
          dptr_q  <= dptr_q + 1'b1;
          sptr_q  <= sptr_q + 1'b1;
          rem_q   <= rem_q - 1'b1;
          if (rem_q == LEN_W'(1)) begin
            state_q <= ST_IDLE;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            cout_q  <= cout_i;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign carry_o = cout_q;
  assign we_o    = (state_q == ST_BYTE);
  assign dptr_o  = dptr_q;
  assign sptr_o  = sptr_q;
  assign bcd_o   = mode_q;
  assign cin_o   = carry_q;

  logic [ADDR_W-1:0] ptr_gap;
  assign ptr_gap = sptr_q - dptr_q;

  AST_REM_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BYTE) |-> (rem_q != '0)); // R2
  AST_DST_IN_GROUP: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BYTE) |-> (dptr_q[ADDR_W-1:GRP_W] == grp_q)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R5
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i) |=> ($stable(mode_q) && $stable(ptr_gap))); // R8
  AST_CARRY_HELD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !start_i) |=> $stable(cout_q)); // R7
endmodule

// File: rtl/regfile_serial_adder.sv
module regfile_serial_adder #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int GRP_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] dst_ptr,
  input  logic [ADDR_W-1:0] src_ptr,
  input  logic              bcd_mode,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              busy,
  output logic              done,
  output logic              carry_out
);
  localparam int DIGITS = DATA_W / 4;

  logic              seq_we, seq_bcd, seq_cin, add_cout;
  logic [ADDR_W-1:0] seq_dptr, seq_sptr;
  logic [DATA_W-1:0] opd_dst, opd_src, add_sum;
  logic              host_ok, rf_we;
  logic [ADDR_W-1:0] rf_waddr;
  logic [DATA_W-1:0] rf_wdata;

  rsa_sequencer #(.ADDR_W(ADDR_W), .GRP_W(GRP_W)) i_seq (
    .clk    (clk),
    .rst    (rst),
    .start_i(start),
    .dst_i  (dst_ptr),
    .src_i  (src_ptr),
    .bcd_i  (bcd_mode),
    .cout_i (add_cout),
    .busy_o (busy),
    .done_o (done),
    .carry_o(carry_out),
    .we_o   (seq_we),
    .dptr_o (seq_dptr),
    .sptr_o (seq_sptr),
    .bcd_o  (seq_bcd),
    .cin_o  (seq_cin)
  );

  rsa_byte_adder #(.DATA_W(DATA_W)) i_add (
    .a   (opd_dst),
    .b   (opd_src),
    .cin (seq_cin),
    .bcd (seq_bcd),
    .sum (add_sum),
    .cout(add_cout)
  );

  assign host_ok  = host_we && !busy;
  assign rf_we    = seq_we || host_ok;
  assign rf_waddr = seq_we ? seq_dptr : host_addr;
  assign rf_wdata = seq_we ? add_sum  : host_wdata;

  rsa_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rf (
    .clk    (clk),
    .we     (rf_we),
    .waddr  (rf_waddr),
    .wdata  (rf_wdata),
    .raddr_a(seq_dptr),
    .rdata_a(opd_dst),
    .raddr_b(seq_sptr),
    .rdata_b(opd_src),
    .haddr  (host_addr),
    .hdata  (host_rdata)
  );

  function automatic logic digits_ok(input logic [DATA_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int g = 0; g < DIGITS; g++) if (v[4*g +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  AST_BCD_DIGITS_VALID: assert property (@(posedge clk) disable iff (rst)
    (seq_we && seq_bcd && digits_ok(opd_dst) && digits_ok(opd_src))
      |-> digits_ok(add_sum)); // R4
  AST_SEQ_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    seq_we |-> busy); // R9
endmodule

// File: tb/test_regfile_serial_adder.sv
module test_regfile_serial_adder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [5:0] dst_ptr = '0, src_ptr = '0;
  logic       bcd_mode = 1'b0;
  logic       host_we = 1'b0;
  logic [5:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       busy, done, carry_out;

  always #10 clk = ~clk;  // 50 MHz

  regfile_serial_adder i_regfile_serial_adder (
    .clk(clk), .rst(rst), .start(start), .dst_ptr(dst_ptr), .src_ptr(src_ptr),
    .bcd_mode(bcd_mode), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
    .done(done), .carry_out(carry_out)
  );

  typedef struct {
    logic  carry;
    int    cycles;
    string req;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] model [64];
  int         n_chk = 0, n_fail = 0;
  int         busy_cnt = 0;
  bit         finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor: counts busy cycles and pops the scoreboard on done
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (busy) busy_cnt++;
        if (done) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R8", "unexpected done", 1, 0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(busy_cnt == e.cycles, "R5", {e.req, " busy cycles"}, busy_cnt, e.cycles);
            check(carry_out == e.carry, "R7", {e.req, " final carry"}, int'(carry_out), int'(e.carry));
          end
          busy_cnt = 0;
        end
      end
    end
  end

  function automatic logic [8:0] ref_byte(input logic [7:0] a, input logic [7:0] b,
                                          input logic c, input logic bcd);
    logic [4:0] raw;
    logic [7:0] s;
    logic       cc;
    if (!bcd) return {1'b0, a} + {1'b0, b} + {8'b0, c};
    cc = c;
    s  = '0;
    for (int g = 0; g < 2; g++) begin
      raw = {1'b0, a[4*g +: 4]} + {1'b0, b[4*g +: 4]} + {4'b0, cc};
      cc  = (raw > 5'd9);
      s[4*g +: 4] = cc ? raw[3:0] + 4'd6 : raw[3:0];
    end
    return {cc, s};
  endfunction

  task automatic host_wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
    model[a] = d;
  endtask

  task automatic dump_check(input string req);
    int bad_a = -1;
    logic [7:0] bad_v = '0;
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      host_addr = 6'(a);
      @(negedge clk);
      if (host_rdata !== model[a] && bad_a < 0) begin
        bad_a = a; bad_v = host_rdata;
      end
    end
    check(bad_a < 0, req, $sformatf("register file R%0o", bad_a < 0 ? 0 : bad_a),
          int'(bad_v), bad_a < 0 ? 0 : int'(model[bad_a]));
  endtask

  task automatic load_all(input bit bcd);
    for (int a = 0; a < 64; a++) begin
      logic [7:0] v;
      v = 8'($urandom);
      if (bcd) v = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
      host_wr(6'(a), v);
    end
  endtask

  // driver: computes expected result, pushes it, issues the command
  task automatic do_add(input logic [5:0] d, input logic [5:0] s, input logic bcd,
                        input string req, input bit poke);
    exp_t e;
    int   len;
    logic c;
    logic [8:0] r;
    len = 8 - int'(d[2:0]);
    c = 1'b0;
    for (int i = 0; i < len; i++) begin
      r = ref_byte(model[6'(d + 6'(i))], model[6'(s + 6'(i))], c, bcd);
      model[6'(d + 6'(i))] = r[7:0];
      c = r[8];
    end
    e.carry = c; e.cycles = 4 + len; e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b1; dst_ptr = d; src_ptr = s; bcd_mode = bcd;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R5", {req, " busy after accept"}, int'(busy), 1);
    check(carry_out == 1'b0, "R7", {req, " carry cleared on start"}, int'(carry_out), 0);
    if (poke) begin
      // R8 / R9: colliding command and host write during the run
      @(negedge clk);
      start = 1'b1; dst_ptr = d ^ 6'o10; src_ptr = s ^ 6'o21; bcd_mode = ~bcd;
      host_we = 1'b1; host_addr = 6'(d + 6'(len - 1)); host_wdata = 8'hA5;
      @(negedge clk);
      start = 1'b0; host_we = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R5 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && carry_out == 1'b0, "R1", "reset outputs",
          {busy, done, carry_out}, 0);

    // R9: write then registered read-back
    host_wr(6'o12, 8'h3C);
    @(negedge clk); host_addr = 6'o12;
    @(negedge clk);
    check(host_rdata == 8'h3C, "R9", "host read-back", host_rdata, 8'h3C);

    load_all(1'b0);
    do_add(6'o60, 6'o50, 1'b0, "R3 full binary", 1'b0);
    dump_check("R3");
    do_add(6'o76, 6'o66, 1'b0, "R2 two-byte", 1'b0);
    dump_check("R2");
    do_add(6'o77, 6'o15, 1'b0, "R2 one-byte", 1'b0);
    dump_check("R2");

    // R3 carry ripple through a full group, R7 hold
    for (int i = 0; i < 8; i++) host_wr(6'(6'o30 + i), 8'hFF);
    host_wr(6'o40, 8'h01);
    for (int i = 1; i < 8; i++) host_wr(6'(6'o40 + i), 8'h00);
    do_add(6'o30, 6'o40, 1'b0, "R3 ripple", 1'b0);
    dump_check("R3");
    repeat (10) @(negedge clk);
    host_wr(6'o5, 8'h11);
    check(carry_out == 1'b1, "R7", "carry held while idle", int'(carry_out), 1);

    // R6 source wrap past R77
    do_add(6'o70, 6'o73, 1'b0, "R6 wrap", 1'b0);
    dump_check("R6");

    // R4 BCD
    load_all(1'b1);
    do_add(6'o60, 6'o50, 1'b1, "R4 full bcd", 1'b0);
    dump_check("R4");
    for (int i = 0; i < 8; i++) host_wr(6'(6'o20 + i), 8'h99);
    host_wr(6'o10, 8'h01);
    for (int i = 1; i < 8; i++) host_wr(6'(6'o10 + i), 8'h00);
    do_add(6'o20, 6'o10, 1'b1, "R4 all nines", 1'b0);
    dump_check("R4");
    host_wr(6'o37, 8'h45); host_wr(6'o47, 8'h55);
    do_add(6'o37, 6'o47, 1'b1, "R4 one-byte decimal carry", 1'b0);
    dump_check("R4");

    // R8 / R9 collision during a run
    do_add(6'o0, 6'o10, 1'b0, "R8 collide", 1'b1);
    dump_check("R9");

    // mixed random commands on BCD-valid data
    load_all(1'b1);
    for (int k = 0; k < 16; k++) begin
      logic [5:0] d, s;
      d = 6'($urandom); s = 6'($urandom);
      do_add(d, s, 1'($urandom), "R3 random", 1'b0);
      // keep data decimal-valid after binary sums
      for (int a = 0; a < 8; a++) host_wr(6'((d & 6'o70) + a), {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))});
    end
    dump_check("R2");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule